// File: doc/BRIEF.md
# Nibble Bit-Slice ALU Core

This block is a purely combinational arithmetic-logic core for 4-bit operands. It is built from identical one-bit slices joined by a ripple carry chain. Each slice forms a generate term and a propagate term from its two operand bits. Three steering lines then decide how each slice treats its incoming carry and what it drives onto its result bit.

There is no opcode decoder and no result multiplexer. Addition, exclusive-or, and, and inclusive-or all come out of the same slices. For the two operations that need it, the caller holds the carry-in at a fixed level. A surrounding datapath uses the block by driving the two operands, the carry-in and the three steering lines. It then reads the result, the carry-out from the top slice and the signed-overflow flag in the same cycle. The block has no clock and no reset.

Top module: `nibble_slice_alu`

## Requirements
- R1: With kill_carry=0, hold_carry=0 and or_sel=0, res equals (opa + opb + carry_in) modulo 16.
- R2: In the mode of R1, carry_out is 1 exactly when opa + opb + carry_in is 16 or more.
- R3: In the mode of R1, ovf is 1 exactly when opa and opb have the same bit 3 and res has a different bit 3 (two's-complement overflow).
- R4: With kill_carry=1, hold_carry=0, or_sel=0 and carry_in=0, res equals opa XOR opb, and carry_out and ovf are 0.
- R5: With kill_carry=0, hold_carry=1, or_sel=0 and carry_in=1, res equals opa AND opb, carry_out is 1 (the held carry passes through every slice) and ovf is 0.
- R6: With kill_carry=1, hold_carry=1, or_sel=1 and carry_in=0, res equals opa OR opb, and carry_out and ovf are 0.
- R7: Whenever or_sel=1, res equals opa OR opb, whatever the values of kill_carry, hold_carry and carry_in.
- R8: With all inputs at 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| carry_in | input | 1 | Carry into the least-significant slice |
| kill_carry | input | 1 | Forces every slice's carry output to 0 |
| hold_carry | input | 1 | Passes each slice's incoming carry straight through; the result bit becomes generate gated by that carry |
| or_sel | input | 1 | Result bit becomes generate OR propagate |
| res | output | 4 | Result |
| carry_out | output | 1 | Carry out of the most-significant slice |
| ovf | output | 1 | Carry into the top slice XOR carry out of it |

## Verification
The bench goes after carries that travel the full chain, such as 0xF + 0xF + 1 and 0xB + 0x4 + 1. A slice with a broken propagate path would return a wrong upper nibble or lose carry_out on these. For overflow it uses sign-crossing sums, such as 0x7 + 0x1 and 0x8 + 0x8. A design that took the flag from the wrong pair of carries would flag unsigned wrap instead. In the logic modes, operand pairs with both bits set would show up a carry that leaks across slices, or a held carry that fails to reach the top. It also checks that or_sel overrides the other steering lines.

// File: rtl/nibble_slice_alu.sv
module nibble_slice_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  input  logic             kill_carry,
  input  logic             hold_carry,
  input  logic             or_sel,
  output logic [WIDTH-1:0] res,
  output logic             carry_out,
  output logic             ovf
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0] cy;
  assign cy[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic gen, prop;
    assign gen = opa[i] & opb[i];
    assign prop = opa[i] ^ opb[i];
    assign cy[i+1] = kill_carry ? 1'b0 :
                     hold_carry ? cy[i] : (gen | (prop & cy[i]));
    assign res[i] = or_sel     ? (gen | prop) :
                    hold_carry ? (gen & cy[i]) : (prop ^ cy[i]);
  end

  assign carry_out = cy[WIDTH];
  assign ovf = cy[WIDTH] ^ cy[TOP];

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (!kill_carry && !hold_carry && !or_sel) begin
      a_r1_sum: assert (res == ref_sum[TOP:0]);
      a_r2_carry: assert (carry_out == ref_sum[WIDTH]);
      a_r3_ovf: assert (ovf == ((opa[TOP] == opb[TOP]) && (res[TOP] != opa[TOP])));
    end
    if (kill_carry && !hold_carry && !or_sel && !carry_in)
      a_r4_xor: assert (res == (opa ^ opb) && !carry_out && !ovf);
    if (!kill_carry && hold_carry && !or_sel && carry_in)
      a_r5_and: assert (res == (opa & opb) && carry_out && !ovf);
    if (kill_carry && hold_carry && or_sel && !carry_in)
      a_r6_or: assert (!carry_out && !ovf);
    if (or_sel)
      a_r7_or_any: assert (res == (opa | opb));
  end

endmodule

// File: tb/sim_nibble_slice_alu.sv
`timescale 1ns/1ps
module sim_nibble_slice_alu;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] opa, opb, res;
  logic carry_in, kill_carry, hold_carry, or_sel, carry_out, ovf;
  int errors = 0, checks = 0;
  int cycles = 0;

  nibble_slice_alu u0 (
    .opa(opa), .opb(opb), .carry_in(carry_in),
    .kill_carry(kill_carry), .hold_carry(hold_carry), .or_sel(or_sel),
    .res(res), .carry_out(carry_out), .ovf(ovf)
  );

  // {kill,hold,or}, cin, a, b, exp res, exp carry, exp ovf, pad
  localparam logic [19:0] VEC [12] = '{
    {3'b000, 1'b0, 4'h7, 4'h1, 4'h8, 1'b0, 1'b1, 2'b00},  // R1 R3
    {3'b000, 1'b1, 4'hB, 4'h4, 4'h0, 1'b1, 1'b0, 2'b00},  // R2
    {3'b000, 1'b0, 4'hD, 4'h6, 4'h3, 1'b1, 1'b0, 2'b00},  // R2
    {3'b000, 1'b0, 4'h8, 4'h8, 4'h0, 1'b1, 1'b1, 2'b00},  // R3
    {3'b000, 1'b1, 4'hF, 4'hF, 4'hF, 1'b1, 1'b0, 2'b00},  // R2
    {3'b000, 1'b0, 4'h5, 4'h2, 4'h7, 1'b0, 1'b0, 2'b00},  // R1
    {3'b100, 1'b0, 4'h9, 4'h5, 4'hC, 1'b0, 1'b0, 2'b00},  // R4
    {3'b100, 1'b0, 4'hF, 4'hF, 4'h0, 1'b0, 1'b0, 2'b00},  // R4
    {3'b010, 1'b1, 4'hA, 4'h6, 4'h2, 1'b1, 1'b0, 2'b00},  // R5
    {3'b010, 1'b1, 4'hF, 4'hF, 4'hF, 1'b1, 1'b0, 2'b00},  // R5
    {3'b111, 1'b0, 4'h9, 4'h4, 4'hD, 1'b0, 1'b0, 2'b00},  // R6
    {3'b111, 1'b0, 4'hF, 4'hF, 4'hF, 1'b0, 1'b0, 2'b00}   // R6
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%h b=%h cin=%b ctl=%b%b%b)",
               tag, act, exp, opa, opb, carry_in, kill_carry, hold_carry, or_sel);
    end
  endtask

  task automatic drive(input logic [2:0] ctl, input logic ci, input logic [3:0] a, input logic [3:0] b);
    {kill_carry, hold_carry, or_sel} = ctl;
    carry_in = ci; opa = a; opb = b;
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8: all-zero inputs
    drive(3'b000, 1'b0, 4'h0, 4'h0);
    check("R8", {3'b0, res, carry_out, ovf}, 8'h00);

    foreach (VEC[i]) begin
      drive(VEC[i][19:17], VEC[i][16], VEC[i][15:12], VEC[i][11:8]);
      check("R1-table res", {4'h0, res}, {4'h0, VEC[i][7:4]});
      check("R2-table carry", {7'h0, carry_out}, {7'h0, VEC[i][3]});
      check("R3-table ovf", {7'h0, ovf}, {7'h0, VEC[i][2]});
    end

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [4:0] s;
          logic v;
          s = 5'(a) + 5'(b) + 5'(ci);
          v = (a[3] == b[3]) && (s[3] != a[3]);
          drive(3'b000, ci[0], a[3:0], b[3:0]);
          check("R1", {4'h0, res}, {4'h0, s[3:0]});
          check("R2", {7'h0, carry_out}, {7'h0, s[4]});
          check("R3", {7'h0, ovf}, {7'h0, v});
        end
        drive(3'b100, 1'b0, a[3:0], b[3:0]);
        check("R4", {2'b0, res, carry_out, ovf}, {2'b0, a[3:0] ^ b[3:0], 2'b00});
        drive(3'b010, 1'b1, a[3:0], b[3:0]);
        check("R5", {2'b0, res, carry_out, ovf}, {2'b0, a[3:0] & b[3:0], 2'b10});
        drive(3'b111, 1'b0, a[3:0], b[3:0]);
        check("R6", {2'b0, res, carry_out, ovf}, {2'b0, a[3:0] | b[3:0], 2'b00});
      end
    end

    // R7: or_sel overrides the other steering lines and carry_in
    for (int k = 0; k < 8; k++) begin
      drive({k[2], k[1], 1'b1}, k[0], 4'hA, 4'h3);
      check("R7", {4'h0, res}, 8'h0B);
      drive({k[2], k[1], 1'b1}, k[0], 4'hC, 4'hC);
      check("R7", {4'h0, res}, 8'h0C);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule